// File: doc/BRIEF.md
# Atomic Reservation Unit

This block owns the one reservation register of a 64-bit core and settles the outcome of load-and-reserve and store-conditional requests. Each request carries an operation, a size code, two register operands, a flag that forces the first operand to zero, and the real address that an external translation stub produced for the effective address. The block forms the effective address and zero-extends load data to the access size. It updates the reservation and decides whether a store-conditional may write memory. It reports the condition-code nibble for that decision.

A load-and-reserve records the access length and the real address. A store-conditional writes only on an exact match of both and then always drops the reservation. A mismatch that falls inside the same smallest real page is an implementation-defined case. A parameter selects its outcome: refused, which is the default, or performed. The result appears one cycle after the request, and a new request may be issued every cycle.

Top module: `rsv_unit`

## Requirements
- R1: The effective address on `res_eaddr` equals `req_rb` plus `req_ra`, with zero used for `req_ra` when `req_ra_zero` is 1.
- R2: A load-and-reserve (`req_op`=0) leaves `rsv_valid`=1, `rsv_len` equal to the access byte count, and `rsv_addr` equal to `req_raddr`. Size codes are 0=1, 1=2, 2=4, 3=8 and 4=16 bytes.
- R3: `ld_result` holds `req_ld_data` with every byte at or above the access byte count forced to zero. For 16 bytes, bits 127:64 belong to the even register and bits 63:0 to the odd register.
- R4: A store-conditional (`req_op`=1) asserts `mem_we` only when a reservation is held, its length equals the store's byte count, and its address equals `req_raddr`. `mem_addr` and `mem_size` carry the request's real address and size code.
- R5: `mem_wdata` carries the low-order bytes of `req_rs` for 1 to 8 bytes, zeros elsewhere. For 16 bytes it carries `{req_rs, req_rs_pair}`.
- R6: When a reservation is held but the length or address differs and the addresses lie in different pages, no write occurs. Pages are compared on the address bits at and above log2(PAGE_BYTES).
- R7: A length or address mismatch within the same page writes nothing when SAME_PAGE_STORES=0. When SAME_PAGE_STORES=1 it writes and reports success.
- R8: For a store-conditional, `cr0` = {0, 0, store performed, `xer_so`}. Bit 1 is the performed flag and bit 0 is the summary-overflow copy. For a load-and-reserve, `cr0` is 0.
- R9: Every store-conditional leaves `rsv_valid`=0, whether or not it wrote.
- R10: A store-conditional issued with no reservation held never writes and reports bit 1 of `cr0` as 0.
- R11: Reset leaves `rsv_valid`=0 and `res_valid`=0.
- R12: `res_valid` and all results appear exactly one cycle after the request. Back-to-back requests each see the reservation left by the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 1 | 0 load-and-reserve, 1 store-conditional |
| req_size | input | 3 | Size code 0..4 (1..16 bytes) |
| req_ra | input | 64 | First address operand |
| req_rb | input | 64 | Second address operand |
| req_ra_zero | input | 1 | Use zero for the first operand |
| req_raddr | input | 64 | Real address of the effective address |
| req_rs | input | 64 | Store source (even register for 16 bytes) |
| req_rs_pair | input | 64 | Odd source register for 16 bytes |
| req_ld_data | input | 128 | Memory data for a load-and-reserve |
| xer_so | input | 1 | Summary-overflow bit |
| res_valid | output | 1 | Result strobe |
| res_eaddr | output | 64 | Effective address |
| mem_we | output | 1 | Memory write enable |
| mem_size | output | 3 | Write size code |
| mem_addr | output | 64 | Write real address |
| mem_wdata | output | 128 | Write data, byte-masked |
| ld_result | output | 128 | Zero-extended load data |
| cr0 | output | 4 | Condition-code nibble |
| rsv_valid | output | 1 | Reservation held |
| rsv_len | output | 5 | Reserved length in bytes |
| rsv_addr | output | 64 | Reserved real address |

## Verification
A reservation that is wrongly kept or lost shows up on the next store-conditional as a wrong `mem_we` and a wrong `cr0` bit 1. Because requests issue back to back, the bench sees that error one cycle after the bad update. A wrong recorded length or address shows at once on `rsv_len` and `rsv_addr` in the cycle after a load-and-reserve. It also makes a later matching store fail. The same-page case is run on both parameter settings, so a swapped page compare separates the two instances.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
    localparam int XLEN   = 64;
    localparam int DATA_W = 2 * XLEN;

    typedef enum logic { OP_LOAD_RSV = 1'b0, OP_STORE_COND = 1'b1 } rsv_op_e;

    typedef enum logic [2:0] {
        SZ_1 = 3'd0, SZ_2 = 3'd1, SZ_4 = 3'd2, SZ_8 = 3'd3, SZ_16 = 3'd4
    } rsv_size_e;

    typedef struct packed {
        logic            valid;
        logic [4:0]      len;
        logic [XLEN-1:0] addr;
    } rsv_state_t;

    function automatic logic [4:0] size_bytes(input logic [2:0] sz);
        case (sz)
            SZ_1:    size_bytes = 5'd1;
            SZ_2:    size_bytes = 5'd2;
            SZ_4:    size_bytes = 5'd4;
            SZ_8:    size_bytes = 5'd8;
            default: size_bytes = 5'd16;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] keep_low_bytes(input logic [DATA_W-1:0] d,
                                                         input logic [2:0] sz);
        logic [DATA_W-1:0] r;
        r = '0;
        for (int b = 0; b < DATA_W/8; b++)
            if (b < int'(size_bytes(sz))) r[b*8 +: 8] = d[b*8 +: 8];
        return r;
    endfunction
endpackage

// File: rtl/rsv_ea_gen.sv
module rsv_ea_gen
    import rsv_pkg::*;
#(
    parameter int AW = XLEN
) (
    input  logic [AW-1:0] op_a,
    input  logic [AW-1:0] op_b,
    input  logic          a_is_zero,
    output logic [AW-1:0] eaddr
);
    logic [AW-1:0] base;
    always_comb begin
        base  = a_is_zero ? '0 : op_a;
        eaddr = op_b + base;
    end
endmodule

// File: rtl/rsv_hold.sv
module rsv_hold
    import rsv_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            set_en,
    input  logic            clr_en,
    input  logic [4:0]      set_len,
    input  logic [XLEN-1:0] set_addr,
    output rsv_state_t      state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else if (set_en) begin
            state.valid <= 1'b1;
            state.len   <= set_len;
            state.addr  <= set_addr;
        end else if (clr_en) begin
            state.valid <= 1'b0;
        end
    end

    a_r9_clear_after_store: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !set_en) |=> !state.valid);
    a_r2_set_records: assert property (@(posedge clk) disable iff (rst)
        set_en |=> (state.valid && state.addr == $past(set_addr) && state.len == $past(set_len)));
endmodule

// File: rtl/rsv_judge.sv
module rsv_judge
    import rsv_pkg::*;
#(
    parameter int PAGE_SHIFT       = 12,
    parameter bit SAME_PAGE_STORES = 1'b0
) (
    input  rsv_state_t      state,
    input  logic [2:0]      size,
    input  logic [XLEN-1:0] raddr,
    output logic            perform
);
    logic exact, same_page;

    always_comb begin
        exact     = state.valid && (state.len == size_bytes(size)) && (state.addr == raddr);
        same_page = state.valid && !exact &&
                    (state.addr[XLEN-1:PAGE_SHIFT] == raddr[XLEN-1:PAGE_SHIFT]);
    end

    generate
        if (SAME_PAGE_STORES) begin : g_same_page_writes
            assign perform = exact || same_page;
        end else begin : g_same_page_refused
            assign perform = exact;
        end
    endgenerate

    always_comb begin
        if (perform)
            a_r10_needs_reservation: assert (state.valid);
    end
endmodule

// File: rtl/rsv_unit.sv
module rsv_unit
    import rsv_pkg::*;
#(
    parameter int PAGE_BYTES       = 4096,
    parameter bit SAME_PAGE_STORES = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_op,
    input  logic [2:0]        req_size,
    input  logic [XLEN-1:0]   req_ra,
    input  logic [XLEN-1:0]   req_rb,
    input  logic              req_ra_zero,
    input  logic [XLEN-1:0]   req_raddr,
    input  logic [XLEN-1:0]   req_rs,
    input  logic [XLEN-1:0]   req_rs_pair,
    input  logic [DATA_W-1:0] req_ld_data,
    input  logic              xer_so,
    output logic              res_valid,
    output logic [XLEN-1:0]   res_eaddr,
    output logic              mem_we,
    output logic [2:0]        mem_size,
    output logic [XLEN-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] ld_result,
    output logic [3:0]        cr0,
    output logic              rsv_valid,
    output logic [4:0]        rsv_len,
    output logic [XLEN-1:0]   rsv_addr
);
    localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);

    logic [XLEN-1:0]   eaddr;
    logic              perform;
    logic              is_store, is_load;
    logic [DATA_W-1:0] src_wide;
    rsv_state_t        state;

    rsv_ea_gen #(.AW(XLEN)) u_ea (
        .op_a(req_ra), .op_b(req_rb), .a_is_zero(req_ra_zero), .eaddr(eaddr)
    );

    assign is_store = req_valid && (req_op == OP_STORE_COND);
    assign is_load  = req_valid && (req_op == OP_LOAD_RSV);

    rsv_hold u_hold (
        .clk(clk), .rst(rst),
        .set_en(is_load), .clr_en(is_store),
        .set_len(size_bytes(req_size)), .set_addr(req_raddr),
        .state(state)
    );

    rsv_judge #(.PAGE_SHIFT(PAGE_SHIFT), .SAME_PAGE_STORES(SAME_PAGE_STORES)) u_judge (
        .state(state), .size(req_size), .raddr(req_raddr), .perform(perform)
    );

    always_comb begin
        if (req_size == SZ_16) src_wide = {req_rs, req_rs_pair};
        else                   src_wide = {{XLEN{1'b0}}, req_rs};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            mem_we    <= 1'b0;
            cr0       <= 4'b0;
            res_eaddr <= '0;
            mem_size  <= '0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            ld_result <= '0;
        end else begin
            res_valid <= req_valid;
            mem_we    <= is_store && perform;
            cr0       <= is_store ? {2'b00, perform, xer_so} : 4'b0;
            res_eaddr <= eaddr;
            mem_size  <= req_size;
            mem_addr  <= req_raddr;
            mem_wdata <= keep_low_bytes(src_wide, req_size);
            ld_result <= keep_low_bytes(req_ld_data, req_size);
        end
    end

    assign rsv_valid = state.valid;
    assign rsv_len   = state.len;
    assign rsv_addr  = state.addr;

    a_r12_one_cycle_result: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);
    a_r8_cr0_layout: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (cr0[3:2] == 2'b00 && cr0[1] == mem_we));
    a_r10_no_write_unreserved: assert property (@(posedge clk) disable iff (rst)
        (is_store && !state.valid) |=> !mem_we);
endmodule

// File: tb/sim_rsv_unit.sv
module sim_rsv_unit;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst, req_valid, req_op, req_ra_zero, xer_so;
    logic [2:0]   req_size;
    logic [63:0]  req_ra, req_rb, req_raddr, req_rs, req_rs_pair;
    logic [127:0] req_ld_data;

    logic         res_valid, mem_we, rsv_valid;
    logic [63:0]  res_eaddr, mem_addr, rsv_addr;
    logic [2:0]   mem_size;
    logic [127:0] mem_wdata, ld_result;
    logic [3:0]   cr0;
    logic [4:0]   rsv_len;

    logic         res_valid_b, mem_we_b, rsv_valid_b;
    logic [63:0]  res_eaddr_b, mem_addr_b, rsv_addr_b;
    logic [2:0]   mem_size_b;
    logic [127:0] mem_wdata_b, ld_result_b;
    logic [3:0]   cr0_b;
    logic [4:0]   rsv_len_b;

    rsv_unit u0 (
        .clk, .rst, .req_valid, .req_op, .req_size, .req_ra, .req_rb, .req_ra_zero,
        .req_raddr, .req_rs, .req_rs_pair, .req_ld_data, .xer_so,
        .res_valid, .res_eaddr, .mem_we, .mem_size, .mem_addr, .mem_wdata,
        .ld_result, .cr0, .rsv_valid, .rsv_len, .rsv_addr
    );

    rsv_unit #(.SAME_PAGE_STORES(1'b1)) u1 (
        .clk, .rst, .req_valid, .req_op, .req_size, .req_ra, .req_rb, .req_ra_zero,
        .req_raddr, .req_rs, .req_rs_pair, .req_ld_data, .xer_so,
        .res_valid(res_valid_b), .res_eaddr(res_eaddr_b), .mem_we(mem_we_b),
        .mem_size(mem_size_b), .mem_addr(mem_addr_b), .mem_wdata(mem_wdata_b),
        .ld_result(ld_result_b), .cr0(cr0_b), .rsv_valid(rsv_valid_b),
        .rsv_len(rsv_len_b), .rsv_addr(rsv_addr_b)
    );

    int checks = 0;
    int failures = 0;
    localparam logic [63:0] XLATE_OFS = 64'h8000_0000;

    // fields: op, size, ra, rb, ra_zero, so, expected write (u0), expected write (u1), reservation after, spare
    localparam int NV = 13;
    localparam logic [41:0] VEC [NV] = '{
        {1'b0, 3'd2, 16'h1000, 16'h0010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // LR word
        {1'b1, 3'd2, 16'h1000, 16'h0010, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R4 match
        {1'b1, 3'd2, 16'h1000, 16'h0010, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R10 no reservation
        {1'b0, 3'd3, 16'h2000, 16'h0008, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // LR dword
        {1'b1, 3'd2, 16'h2000, 16'h0008, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R7 length mismatch same page
        {1'b0, 3'd0, 16'h3000, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // LR byte
        {1'b1, 3'd0, 16'h5000, 16'h0001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 other page
        {1'b0, 3'd1, 16'hFFFF, 16'h4002, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R1 ra forced zero
        {1'b1, 3'd1, 16'h0000, 16'h4002, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R4 halfword
        {1'b0, 3'd4, 16'h6000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // LR quad
        {1'b1, 3'd4, 16'h6000, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R4 quad, so=1
        {1'b0, 3'd2, 16'h7000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // LR word
        {1'b1, 3'd2, 16'h7000, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}  // R7 addr mismatch same page
    };

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic op, input logic [2:0] sz, input logic [63:0] ra,
                         input logic [63:0] rb, input logic rz, input logic so,
                         input logic [63:0] rs, input logic [63:0] pair, input logic [127:0] ld);
        logic [63:0] ea;
        ea = rb + (rz ? 64'd0 : ra);
        req_valid = 1'b1; req_op = op; req_size = sz; req_ra = ra; req_rb = rb;
        req_ra_zero = rz; xer_so = so; req_rs = rs; req_rs_pair = pair; req_ld_data = ld;
        req_raddr = ea + XLATE_OFS;
    endtask

    task automatic idle();
        req_valid = 1'b0; req_op = 1'b0; req_size = 3'd0; req_ra = '0; req_rb = '0;
        req_ra_zero = 1'b0; xer_so = 1'b0; req_rs = '0; req_rs_pair = '0; req_ld_data = '0;
        req_raddr = '0;
    endtask

    task automatic check_vec(input int i);
        logic [41:0] v;
        logic [63:0] ea;
        logic [4:0]  bytes;
        v  = VEC[i];
        ea = {48'd0, v[21:6]} + (v[5] ? 64'd0 : {48'd0, v[37:22]});
        bytes = 5'd1 << v[40:38];
        check("R12 res_valid", {127'd0, res_valid}, 128'd1);
        check("R1 effective address", {64'd0, res_eaddr}, {64'd0, ea});
        check("R4 write enable", {127'd0, mem_we}, {127'd0, v[3]});
        check("R7 write enable, same-page stores on", {127'd0, mem_we_b}, {127'd0, v[2]});
        check("R8 cr0", {124'd0, cr0}, v[41] ? {124'd0, 2'b00, v[3], v[4]} : 128'd0);
        check("R9 reservation flag", {127'd0, rsv_valid}, {127'd0, v[1]});
        if (v[41]) begin
            check("R4 write address", {64'd0, mem_addr}, {64'd0, ea + XLATE_OFS});
            check("R4 write size", {125'd0, mem_size}, {125'd0, v[40:38]});
        end else begin
            check("R2 reserved length", {123'd0, rsv_len}, {123'd0, bytes});
            check("R2 reserved address", {64'd0, rsv_addr}, {64'd0, ea + XLATE_OFS});
        end
    endtask

    task automatic print_summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        print_summary();
        $finish;
    end

    initial begin
        logic [41:0] v;
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R11 reset reservation", {127'd0, rsv_valid}, 128'd0);
        check("R11 reset res_valid", {127'd0, res_valid}, 128'd0);

        // back-to-back table walk: check vector i-1 while driving vector i
        for (int i = 0; i <= NV; i++) begin
            if (i > 0) check_vec(i - 1);
            if (i < NV) begin
                v = VEC[i];
                drive(v[41], v[40:38], {48'd0, v[37:22]}, {48'd0, v[21:6]}, v[5], v[4],
                      64'h1122_3344_5566_7788, 64'h99AA_BBCC_DDEE_FF00, {128{1'b1}});
            end else idle();
            @(negedge clk);
        end
        check("R12 idle gives no result", {127'd0, res_valid}, 128'd0);

        // R3 zero extension of load data
        drive(1'b0, 3'd0, 64'h100, 64'h0, 1'b0, 1'b0, '0, '0, {128{1'b1}});
        @(negedge clk);
        check("R3 byte load", ld_result, 128'hFF);
        drive(1'b0, 3'd2, 64'h100, 64'h0, 1'b0, 1'b0, '0, '0, {128{1'b1}});
        @(negedge clk);
        check("R3 word load", ld_result, 128'hFFFF_FFFF);
        drive(1'b0, 3'd4, 64'h100, 64'h0, 1'b0, 1'b0, '0, '0, {128{1'b1}});
        @(negedge clk);
        check("R3 quad load", ld_result, {128{1'b1}});

        // R5 store data selection
        drive(1'b0, 3'd1, 64'h200, 64'h0, 1'b0, 1'b0, '0, '0, '0);
        @(negedge clk);
        drive(1'b1, 3'd1, 64'h200, 64'h0, 1'b0, 1'b0, 64'h1122_3344_5566_7788, 64'hFFFF, '0);
        @(negedge clk);
        check("R5 halfword store data", mem_wdata, 128'h7788);
        check("R5 halfword store performed", {127'd0, mem_we}, 128'd1);
        drive(1'b0, 3'd3, 64'h300, 64'h0, 1'b0, 1'b0, '0, '0, '0);
        @(negedge clk);
        drive(1'b1, 3'd3, 64'h300, 64'h0, 1'b0, 1'b0, 64'h1122_3344_5566_7788, 64'hFFFF, '0);
        @(negedge clk);
        check("R5 dword store data", mem_wdata, 128'h1122_3344_5566_7788);
        drive(1'b0, 3'd4, 64'h400, 64'h0, 1'b0, 1'b0, '0, '0, '0);
        @(negedge clk);
        drive(1'b1, 3'd4, 64'h400, 64'h0, 1'b0, 1'b0, 64'hAAAA_0000_0000_BBBB, 64'h0123_4567_89AB_CDEF, '0);
        @(negedge clk);
        check("R5 quad store data", mem_wdata, 128'hAAAA_0000_0000_BBBB_0123_4567_89AB_CDEF);

        // R11 reset drops a held reservation, then a store is refused (R10)
        drive(1'b0, 3'd2, 64'h500, 64'h0, 1'b0, 1'b0, '0, '0, '0);
        @(negedge clk);
        idle();
        check("R2 reservation held before reset", {127'd0, rsv_valid}, 128'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 reset clears reservation", {127'd0, rsv_valid}, 128'd0);
        drive(1'b1, 3'd2, 64'h500, 64'h0, 1'b0, 1'b1, '0, '0, '0);
        @(negedge clk);
        idle();
        check("R10 store after reset not performed", {127'd0, mem_we}, 128'd0);
        check("R10 cr0 after reset", {124'd0, cr0}, 128'h1);
        @(negedge clk);

        print_summary();
        $finish;
    end
endmodule